// File: doc/BRIEF.md
# Debug Memory Access Sequencer

This block carries out reads and writes that a debugger asks for, aimed at either CPU memory or the CPU register file. The debugger programs four registers over a small register bus: a control word, a start address, a data value and a repeat count. Setting the start bit launches either one access or a burst of accesses on a request/ready access port. During a burst, the address and count registers are updated in place after every completed access.

Each access holds its request, with address and write data stable, until the target answers with ready. A read stores the returned value in the data register. A byte read returns the value zero-extended. A write sends whatever the data register holds. The address step is 1 for byte accesses and 2 for word accesses. A byte access aimed at the register file is not allowed, so the sequencer turns it into a word access.

Top module: `dbg_mem_seq`

## Requirements
- R1: After reset, the control, address, data and count registers all read as zero, the busy flag is 0 and no request is raised.
- R2: Register-bus offsets are 0 = control, 1 = address, 2 = data and 3 = count. The control bits are 0 = start, 1 = write (1 = write, 0 = read), 2 = target (1 = CPU register, 0 = memory), 3 = byte (1 = 8-bit access) and 4 = busy (read only).
- R3: When the control word is written with both the target bit and the byte bit set, the byte bit is stored as 0 and every access is a word access.
- R4: With a count of zero, start performs exactly one access, and the address and count registers keep their values.
- R5: With a nonzero count N, start performs exactly N accesses. The count drops by one after each completed access and ends at zero.
- R6: During a burst, the address advances after each completed access, by 1 for byte accesses and by 2 for word accesses. It ends at the first address plus N times the step.
- R7: A read stores the returned value in the data register. For a byte read, the low 8 bits are stored and the upper bits are zero.
- R8: A write drives the data register's value on the write-data output.
- R9: The request stays high with address, write data and direction stable until ready is seen. The address and count change only on a cycle in which ready is high.
- R10: The request rises in the cycle after the control write that sets start. Busy reads 1 while the transfer runs. Start and busy both clear when the last access completes.
- R11: Register-bus writes made while busy is set have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register-bus write strobe |
| bus_sel | input | 2 | Register-bus register select |
| bus_wdata | input | 16 | Register-bus write data |
| bus_rdata | output | 16 | Register-bus read data of the selected register |
| acc_req | output | 1 | Access request |
| acc_wr | output | 1 | Access is a write |
| acc_reg | output | 1 | Access targets the CPU register file |
| acc_byte | output | 1 | Access is 8-bit |
| acc_addr | output | 16 | Access address or register number |
| acc_wdata | output | 16 | Access write data |
| acc_rdata | input | 16 | Access read data, valid with ready |
| acc_ready | input | 1 | Target completes the current access |

## Verification
A control write that is sampled at edge E raises the request right after E. An access that sees ready at edge F shows its updated data, address and count, and the cleared busy flag on its last access, right after F. Register reads are combinational, so the bench drives inputs and samples reads on falling edges. It waits for busy to clear by polling the control register, rather than counting a fixed number of cycles, because its access model inserts a chosen number of wait cycles before ready. The cycle-level rules (request hold, count and address steps, read capture) are checked by assertions on the edge after each completion.

// File: rtl/dbg_mem_pkg.sv
package dbg_mem_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    localparam int CB_START = 0;
    localparam int CB_WR    = 1;
    localparam int CB_TGT   = 2;
    localparam int CB_BYTE  = 3;
    localparam int CB_BUSY  = 4;
endpackage

// File: rtl/dbg_mem_bus_dec.sv
module dbg_mem_bus_dec
    import dbg_mem_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          bus_we,
    input  logic [1:0]    bus_sel,
    input  logic [DW-1:0] bus_wdata,
    input  logic          busy,
    input  logic [3:0]    ctrl_bits,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic [CW-1:0] cnt,
    output logic          wr_ctrl,
    output logic          wr_addr,
    output logic          wr_data,
    output logic          wr_cnt,
    output logic [DW-1:0] rdata
);
    logic we_ok;
    assign we_ok   = bus_we & ~busy;
    assign wr_ctrl = we_ok & (bus_sel == SEL_CTRL);
    assign wr_addr = we_ok & (bus_sel == SEL_ADDR);
    assign wr_data = we_ok & (bus_sel == SEL_DATA);
    assign wr_cnt  = we_ok & (bus_sel == SEL_CNT);

    always_comb begin
        rdata = '0;
        unique case (reg_sel_e'(bus_sel))
            SEL_CTRL: begin
                rdata[3:0]     = ctrl_bits;
                rdata[CB_BUSY] = busy;
            end
            SEL_ADDR: rdata = DW'(addr);
            SEL_DATA: rdata = data;
            SEL_CNT:  rdata = DW'(cnt);
        endcase
    end
endmodule

// File: rtl/dbg_mem_step.sv
module dbg_mem_step #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic          byte_mode,
    output logic [AW-1:0] addr_nxt
);
    localparam int WORD_STEP = DW / 8;
    assign addr_nxt = addr + (byte_mode ? AW'(1) : AW'(WORD_STEP));
endmodule

// File: rtl/dbg_mem_rd_fmt.sv
module dbg_mem_rd_fmt #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] raw,
    input  logic          byte_mode,
    output logic [DW-1:0] fmt
);
    generate
        if (DW > 8) begin : g_wide
            assign fmt = byte_mode ? {{(DW-8){1'b0}}, raw[7:0]} : raw;
        end else begin : g_narrow
            logic unused_mode;
            assign unused_mode = byte_mode;
            assign fmt = raw;
        end
    endgenerate
endmodule

// File: rtl/dbg_mem_seq.sv
module dbg_mem_seq
    import dbg_mem_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [1:0]    bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          acc_req,
    output logic          acc_wr,
    output logic          acc_reg,
    output logic          acc_byte,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata,
    input  logic [DW-1:0] acc_rdata,
    input  logic          acc_ready
);
    typedef struct packed {
        logic          busy;
        logic          start;
        logic          wr;
        logic          tgt;
        logic          byte_m;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    logic          wr_ctrl, wr_addr, wr_data, wr_cnt;
    logic [AW-1:0] addr_nxt;
    logic [DW-1:0] rd_fmt;
    logic          done;

    logic          busy_cur;
    logic [AW-1:0] addr_cur;
    logic [DW-1:0] data_cur;
    logic [CW-1:0] cnt_cur;

    dbg_mem_bus_dec #(.AW(AW), .DW(DW), .CW(CW)) u_dec (
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .busy      (s_q.busy),
        .ctrl_bits ({s_q.byte_m, s_q.tgt, s_q.wr, s_q.start}),
        .addr      (s_q.addr),
        .data      (s_q.data),
        .cnt       (s_q.cnt),
        .wr_ctrl   (wr_ctrl),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_cnt    (wr_cnt),
        .rdata     (bus_rdata)
    );

    dbg_mem_step #(.AW(AW), .DW(DW)) u_step (
        .addr      (s_q.addr),
        .byte_mode (s_q.byte_m),
        .addr_nxt  (addr_nxt)
    );

    dbg_mem_rd_fmt #(.DW(DW)) u_fmt (
        .raw       (acc_rdata),
        .byte_mode (s_q.byte_m),
        .fmt       (rd_fmt)
    );

    assign done = s_q.busy & acc_ready;

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) begin
            s_d.start  = bus_wdata[CB_START];
            s_d.busy   = bus_wdata[CB_START];
            s_d.wr     = bus_wdata[CB_WR];
            s_d.tgt    = bus_wdata[CB_TGT];
            // register-file targets only take word accesses
            s_d.byte_m = bus_wdata[CB_BYTE] & ~bus_wdata[CB_TGT];
        end
        if (wr_addr) s_d.addr = AW'(bus_wdata);
        if (wr_data) s_d.data = bus_wdata;
        if (wr_cnt)  s_d.cnt  = CW'(bus_wdata);
        if (done) begin
            if (!s_q.wr) s_d.data = rd_fmt;
            if (s_q.cnt != '0) begin
                s_d.cnt  = s_q.cnt - CW'(1);
                s_d.addr = addr_nxt;
            end
            if (s_q.cnt <= CW'(1)) begin
                s_d.busy  = 1'b0;
                s_d.start = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc_req   = s_q.busy;
    assign acc_wr    = s_q.wr;
    assign acc_reg   = s_q.tgt;
    assign acc_byte  = s_q.byte_m;
    assign acc_addr  = s_q.addr;
    assign acc_wdata = s_q.data;

    assign busy_cur = s_q.busy;
    assign addr_cur = s_q.addr;
    assign data_cur = s_q.data;
    assign cnt_cur  = s_q.cnt;
endmodule

// File: rtl/dbg_mem_seq_chk.sv
module dbg_mem_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_req,
    input logic          acc_ready,
    input logic          acc_wr,
    input logic          acc_reg,
    input logic          acc_byte,
    input logic [AW-1:0] acc_addr,
    input logic [DW-1:0] acc_wdata,
    input logic [DW-1:0] acc_rdata,
    input logic          busy_cur,
    input logic [AW-1:0] addr_cur,
    input logic [DW-1:0] data_cur,
    input logic [CW-1:0] cnt_cur
);
    localparam int WSTEP = DW / 8;
    logic [DW-1:0] rd_exp;
    assign rd_exp = acc_byte ? (acc_rdata & DW'(8'hFF)) : acc_rdata;

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_ready |=> acc_req && $stable(acc_addr) && $stable(acc_wdata) && $stable(acc_wr));

    a_r9_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_ready |=> $stable(cnt_cur) && $stable(addr_cur));

    a_r3_no_byte_reg: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |-> !(acc_byte && acc_reg));

    a_r5_cnt_dec: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ready && cnt_cur != '0 |=> cnt_cur == $past(cnt_cur) - CW'(1));

    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ready && cnt_cur != '0 |=>
        addr_cur == $past(addr_cur) + ($past(acc_byte) ? AW'(1) : AW'(WSTEP)));

    a_r4_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ready && cnt_cur == '0 |=> !busy_cur && $stable(addr_cur) && $stable(cnt_cur));

    a_r7_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ready && !acc_wr |=> data_cur == $past(rd_exp));
endmodule

bind dbg_mem_seq dbg_mem_seq_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_req   (acc_req),
    .acc_ready (acc_ready),
    .acc_wr    (acc_wr),
    .acc_reg   (acc_reg),
    .acc_byte  (acc_byte),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .busy_cur  (busy_cur),
    .addr_cur  (addr_cur),
    .data_cur  (data_cur),
    .cnt_cur   (cnt_cur)
);

// File: tb/dbg_mem_seq_tb.sv
module dbg_mem_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        acc_req, acc_wr, acc_reg, acc_byte;
    logic [15:0] acc_addr, acc_wdata, acc_rdata;
    logic        acc_ready;

    int          tests = 0;
    int          fails = 0;

    // access target model: ready after wait_n stall cycles, data = addr ^ 16'h5A3C
    int          wait_n = 0;
    int          wcnt = 0;
    logic        log_clr = 1'b0;
    int          n_acc = 0;
    logic [15:0] last_addr = 16'h0;
    logic [15:0] last_wdata = 16'h0;
    logic        saw_byte = 1'b0;

    assign acc_ready = acc_req && (wcnt == wait_n);
    assign acc_rdata = acc_addr ^ 16'h5A3C;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_mem_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .acc_req(acc_req),
        .acc_wr(acc_wr), .acc_reg(acc_reg), .acc_byte(acc_byte),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_ready(acc_ready)
    );

    always @(posedge clk) begin
        if (acc_req && !acc_ready) wcnt <= wcnt + 1;
        else                       wcnt <= 0;
        if (log_clr) begin
            n_acc <= 0; saw_byte <= 1'b0;
        end else if (acc_req && acc_ready) begin
            n_acc      <= n_acc + 1;
            last_addr  <= acc_addr;
            last_wdata <= acc_wdata;
            saw_byte   <= saw_byte | acc_byte;
        end
    end

    typedef struct packed {
        logic [3:0]  ctrl;
        logic [15:0] addr;
        logic [15:0] data;
        logic [15:0] cnt;
        logic [3:0]  wt;
        logic [7:0]  nacc;
        logic [15:0] faddr;
        logic [15:0] fdata;
        logic [15:0] last;
        logic [15:0] ctrl_rb;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'h1, 16'h0100, 16'h0000, 16'd0, 4'd0, 8'd1, 16'h0100, 16'h5B3C, 16'h0100, 16'h0000},
        '{4'h9, 16'h0201, 16'h0000, 16'd0, 4'd1, 8'd1, 16'h0201, 16'h003D, 16'h0201, 16'h0008},
        '{4'h3, 16'h0300, 16'hBEEF, 16'd0, 4'd0, 8'd1, 16'h0300, 16'hBEEF, 16'h0300, 16'h0002},
        '{4'h1, 16'h1000, 16'h0000, 16'd4, 4'd2, 8'd4, 16'h1008, 16'h4A3A, 16'h1006, 16'h0000},
        '{4'hB, 16'h2001, 16'h1234, 16'd3, 4'd0, 8'd3, 16'h2004, 16'h1234, 16'h2003, 16'h000A},
        '{4'h5, 16'h0005, 16'h0000, 16'd0, 4'd0, 8'd1, 16'h0005, 16'h5A39, 16'h0005, 16'h0004},
        '{4'hF, 16'h0007, 16'h7777, 16'd2, 4'd1, 8'd2, 16'h000B, 16'h7777, 16'h0009, 16'h0006},
        '{4'h1, 16'h4000, 16'h0000, 16'd1, 4'd0, 8'd1, 16'h4002, 16'h1A3C, 16'h4000, 16'h0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = val;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] sel, output logic [15:0] val);
        @(negedge clk);
        bus_sel = sel;
        #1 val = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 400; i++) begin
            bus_read(2'd0, v);
            if (!v[4]) return;
        end
        check("R10 busy never cleared", 32'(v[4]), 32'd0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            bus_read(2'(s), v);
            check("R1 reset register value", 32'(v), 32'd0);
        end
        check("R1 no request after reset", 32'(acc_req), 32'd0);

        // vector table: R2..R8, R10
        foreach (VECS[i]) begin
            wait_n = int'(VECS[i].wt);
            bus_write(2'd1, VECS[i].addr);
            bus_write(2'd2, VECS[i].data);
            bus_write(2'd3, VECS[i].cnt);
            @(negedge clk); log_clr = 1'b1;
            @(negedge clk); log_clr = 1'b0;
            bus_write(2'd0, {12'h0, VECS[i].ctrl});
            wait_idle();
            check("R4 R5 access count", 32'(n_acc), 32'(VECS[i].nacc));
            bus_read(2'd1, v);
            check("R6 R4 final address", 32'(v), 32'(VECS[i].faddr));
            bus_read(2'd2, v);
            check("R7 data register", 32'(v), 32'(VECS[i].fdata));
            bus_read(2'd3, v);
            check("R5 final count", 32'(v), 32'd0);
            check("R6 last access address", 32'(last_addr), 32'(VECS[i].last));
            bus_read(2'd0, v);
            check("R2 R3 R10 control readback", 32'(v), 32'(VECS[i].ctrl_rb));
            check("R3 byte lane seen", 32'(saw_byte),
                  32'(VECS[i].ctrl[3] & ~VECS[i].ctrl[2]));
            if (VECS[i].ctrl[1])
                check("R8 write data", 32'(last_wdata), 32'(VECS[i].data));
        end

        // R9 R10 R11: request timing, hold during stalls, writes ignored while busy
        wait_n = 6;
        bus_write(2'd1, 16'h0800);
        bus_write(2'd3, 16'h0000);
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        @(negedge clk);
        bus_we = 1'b1; bus_sel = 2'd0; bus_wdata = 16'h0001;
        @(negedge clk);
        bus_we = 1'b0;
        check("R10 request one cycle after start", 32'(acc_req), 32'd1);
        bus_read(2'd0, v);
        check("R10 busy while running", 32'(v[4]), 32'd1);
        bus_write(2'd1, 16'hFFFF);
        bus_write(2'd3, 16'h0005);
        check("R9 address held during stall", 32'(acc_addr), 32'h0800);
        check("R9 request held during stall", 32'(acc_req), 32'd1);
        wait_idle();
        bus_read(2'd1, v);
        check("R11 address write ignored while busy", 32'(v), 32'h0800);
        bus_read(2'd3, v);
        check("R11 count write ignored while busy", 32'(v), 32'd0);
        check("R4 single access with stalls", 32'(n_acc), 32'd1);
        bus_read(2'd2, v);
        check("R7 stalled read data", 32'(v), 32'h0800 ^ 32'h5A3C);

        finish_run();
    end
endmodule